// File: doc/BRIEF.md
# Gapped Send/Receive Timing Generator

This block sits on the line-equipment side of a high-speed serial link and produces the two timing outputs for the terminal: a send-timing clock and a receive-timing clock. Both are derived from a faster reference clock that runs at a whole multiple `DIV` of the bit rate. The reference is cut into bit slots of `DIV` cycles. In each slot a channel either issues one pulse, high for `HI = ceil(DIV/2)` reference cycles from the start of the slot, or omits it. Omitted pulses (gaps) delete framing positions or limit bandwidth. Along with each clock level the block gives a one-cycle enable strobe that marks the rising edge.

Each channel has a small state machine with three states. `CH_OFF` means the clock is stopped. `CH_RUN` means pulses are issued. `CH_HOLD` means a disable request is waiting for its release conditions. The named transitions are:
- `OFF->RUN`: at a slot start with no disable request.
- `RUN->OFF` and `HOLD->OFF`: at a slot start, when disable is requested, the trailing-pulse rule is met and the two ends are not both available.
- `RUN->HOLD`: when disable is requested but the rule is not yet met.
- `HOLD->RUN`: when the request is withdrawn.
- `ANY->OFF`: on a force-off.

After the last valid data marker, the receive channel must issue 23 trailing pulses before it may stop. The send channel needs only 1. At elaboration the block checks that `DIV` reference periods are no shorter than the minimum bit period (about 19.23 ns) and that `HI` periods cover the 7.7 ns minimum high time.

Top module: `gapped_tmg_gen`

## Requirements
- R1: While reset is active and at the first sample after it, both timing outputs, both enable strobes and both error flags are 0.
- R2: Slot boundaries fall every `DIV` reference cycles from reset. A pulse rises only at a slot boundary and stays high exactly `HI = ceil(DIV/2)` cycles (`HI = 2` for the default `DIV = 4`). Its enable strobe is high for exactly the first of those cycles. Rising edges are never closer than `DIV` cycles.
- R3: A stopped channel whose disable request is low begins pulsing at the next slot boundary, and then issues one pulse per slot.
- R4: A gap request present at a slot boundary omits that slot's pulse. While both available inputs are 1, a gap request in the slot right after an omitted slot is ignored, so at most one pulse in a row is omitted.
- R5: While either available input is 0, every gap request is honored, so gaps of any length are allowed.
- R6: After a last-valid marker on the receive channel, that channel issues at least 23 pulses (counting a pulse that starts in the marker's cycle) before a disable request stops it. It stops at the first slot boundary after the 23rd pulse.
- R7: After a last-valid marker on the send channel, that channel issues at least 1 pulse before a disable request stops it.
- R8: While both available inputs are 1, a disable request never stops a running channel.
- R9: A disable request that cannot yet be honored is held. The channel keeps pulsing, and withdrawing the request returns it to normal running.
- R10: A force-off drives that channel's clock and strobe low at the next edge and stops it. If the trailing-pulse count is incomplete at that moment, the channel's error flag is set and stays set until reset.
- R11: A last-valid marker that arrives while a channel is stopped has no effect on its trailing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, `DIV` cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dte_avail_i | input | 1 | Terminal side available |
| dce_avail_i | input | 1 | Line equipment side available |
| snd_gap_i | input | 1 | Omit the send pulse of the current slot |
| snd_stop_i | input | 1 | Disable request for send timing |
| snd_last_i | input | 1 | Last valid send-data marker |
| snd_kill_i | input | 1 | External force-off of send timing |
| rcv_gap_i | input | 1 | Omit the receive pulse of the current slot |
| rcv_stop_i | input | 1 | Disable request for receive timing |
| rcv_last_i | input | 1 | Last valid receive-data marker |
| rcv_kill_i | input | 1 | External force-off of receive timing |
| snd_tmg_o | output | 1 | Send timing clock level |
| snd_en_o | output | 1 | Send pulse rising-edge strobe |
| snd_err_o | output | 1 | Sticky send trailing-rule violation |
| rcv_tmg_o | output | 1 | Receive timing clock level |
| rcv_en_o | output | 1 | Receive pulse rising-edge strobe |
| rcv_err_o | output | 1 | Sticky receive trailing-rule violation |

## Verification
The bench holds a gap request high on every slot while both ends are available. A design that lacked the single-gap limit would go silent instead of alternating. It then drops one available input to confirm that long gaps are granted. It counts pulses after a marker combined with a disable request: a receive channel that stopped early would show fewer than 23, and one that confused the two channels' rules would show 23 on send or 1 on receive. It also sends a marker while a channel is stopped, withdraws a held disable, and forces a channel off mid-drain. These catch a marker that rearms a stopped channel, a hold that never releases, and an error flag that misses the violation or clears itself. Random stimulus is then checked cycle by cycle against a bench model.

// File: rtl/gapped_tmg_pkg.sv
package gapped_tmg_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HOLD = 2'd2
    } chan_state_e;

    function automatic int unsigned high_cycles(input int unsigned div);
        return (div + 1) / 2;
    endfunction

endpackage

// File: rtl/gapped_tmg_slot.sv
module gapped_tmg_slot #(
    parameter int unsigned DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic slot_o,
    output logic hi_end_o
);
    localparam int unsigned HI = gapped_tmg_pkg::high_cycles(DIV);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(DIV - 1);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q <= '0;
        end else if (ph_q == LAST_PH) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PW'(1);
        end
    end

    assign slot_o   = (ph_q == '0);
    assign hi_end_o = (ph_q == PW'(HI));
endmodule

// File: rtl/gapped_tmg_chan.sv
module gapped_tmg_chan #(
    parameter int unsigned TRAIL = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slot_i,
    input  logic hi_end_i,
    input  logic both_i,
    input  logic gap_i,
    input  logic stop_i,
    input  logic last_i,
    input  logic kill_i,
    output logic tmg_o,
    output logic en_o,
    output logic err_o,
    output logic on_o
);
    import gapped_tmg_pkg::*;

    localparam int unsigned CW = $clog2(TRAIL + 1);
    localparam logic [CW-1:0] FULL = CW'(TRAIL);

    chan_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_mark, cnt_d;
    logic gap_prev_q;
    logic may_stop, gap_take, issue;

    // marker resets the trailing count, but only while the clock runs (R11)
    assign cnt_mark = (last_i && (state_q != CH_OFF)) ? '0 : cnt_q;
    assign may_stop = (cnt_mark == FULL) && !both_i;
    // single gaps only while both ends are available (R4, R5)
    assign gap_take = gap_i && (!both_i || !gap_prev_q);

    always_comb begin
        state_d = state_q;
        if (kill_i) begin
            state_d = CH_OFF;
        end else if (slot_i) begin
            unique case (state_q)
                CH_OFF:  state_d = stop_i ? CH_OFF : CH_RUN;
                CH_RUN:  state_d = !stop_i ? CH_RUN : (may_stop ? CH_OFF : CH_HOLD);
                CH_HOLD: state_d = !stop_i ? CH_RUN : (may_stop ? CH_OFF : CH_HOLD);
                default: state_d = CH_OFF;
            endcase
        end
    end

    assign issue = slot_i && !kill_i && (state_d != CH_OFF) && !gap_take;
    assign cnt_d = (issue && (cnt_mark != FULL)) ? cnt_mark + CW'(1) : cnt_mark;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and per-channel bookkeeping
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmg_o      <= 1'b0;
            en_o       <= 1'b0;
            err_o      <= 1'b0;
            gap_prev_q <= 1'b0;
            cnt_q      <= FULL;
        end else begin
            cnt_q <= cnt_d;
            if (kill_i) begin
                tmg_o      <= 1'b0;
                en_o       <= 1'b0;
                gap_prev_q <= 1'b0;
                if (cnt_mark != FULL) begin
                    err_o <= 1'b1;
                end
            end else begin
                en_o <= issue;
                if (slot_i) begin
                    tmg_o      <= issue;
                    gap_prev_q <= (state_d != CH_OFF) && !issue;
                end else if (hi_end_i) begin
                    tmg_o <= 1'b0;
                end
            end
        end
    end

    assign on_o = (state_q != CH_OFF);
endmodule

// File: rtl/gapped_tmg_gen.sv
module gapped_tmg_gen #(
    parameter int unsigned DIV          = 4,
    parameter int unsigned REF_PS       = 5000,
    parameter int unsigned MIN_BIT_PS   = 19231,
    parameter int unsigned MIN_HIGH_PS  = 7700,
    parameter int unsigned SND_TRAIL    = 1,
    parameter int unsigned RCV_TRAIL    = 23
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dte_avail_i,
    input  logic dce_avail_i,
    input  logic snd_gap_i,
    input  logic snd_stop_i,
    input  logic snd_last_i,
    input  logic snd_kill_i,
    input  logic rcv_gap_i,
    input  logic rcv_stop_i,
    input  logic rcv_last_i,
    input  logic rcv_kill_i,
    output logic snd_tmg_o,
    output logic snd_en_o,
    output logic snd_err_o,
    output logic rcv_tmg_o,
    output logic rcv_en_o,
    output logic rcv_err_o
);
    localparam int unsigned HI = gapped_tmg_pkg::high_cycles(DIV);

    if (DIV < 2) begin : g_bad_div
        $error("DIV must be at least 2");
    end
    if (DIV * REF_PS < MIN_BIT_PS) begin : g_bad_rate
        $error("slot shorter than the minimum bit period");
    end
    if (HI * REF_PS < MIN_HIGH_PS) begin : g_bad_high
        $error("pulse high time below the minimum");
    end

    logic slot, hi_end, both;
    logic snd_on, rcv_on;

    assign both = dte_avail_i && dce_avail_i;

    gapped_tmg_slot #(.DIV(DIV)) u_slot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .slot_o   (slot),
        .hi_end_o (hi_end)
    );

    gapped_tmg_chan #(.TRAIL(SND_TRAIL)) u_snd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .slot_i   (slot),
        .hi_end_i (hi_end),
        .both_i   (both),
        .gap_i    (snd_gap_i),
        .stop_i   (snd_stop_i),
        .last_i   (snd_last_i),
        .kill_i   (snd_kill_i),
        .tmg_o    (snd_tmg_o),
        .en_o     (snd_en_o),
        .err_o    (snd_err_o),
        .on_o     (snd_on)
    );

    gapped_tmg_chan #(.TRAIL(RCV_TRAIL)) u_rcv (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .slot_i   (slot),
        .hi_end_i (hi_end),
        .both_i   (both),
        .gap_i    (rcv_gap_i),
        .stop_i   (rcv_stop_i),
        .last_i   (rcv_last_i),
        .kill_i   (rcv_kill_i),
        .tmg_o    (rcv_tmg_o),
        .en_o     (rcv_en_o),
        .err_o    (rcv_err_o),
        .on_o     (rcv_on)
    );
endmodule

// File: rtl/gapped_tmg_chk.sv
module gapped_tmg_chk #(
    parameter int unsigned DIV   = 4,
    parameter int unsigned TRAIL = 1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic tmg,
    input logic en,
    input logic err,
    input logic kill,
    input logic last,
    input logic on
);
    localparam int unsigned HI = gapped_tmg_pkg::high_cycles(DIV);
    localparam int unsigned SW = $clog2(DIV + 1);
    localparam int unsigned HW = $clog2(HI + 2);
    localparam int unsigned CW = $clog2(TRAIL + 1);

    logic [SW-1:0] spc;
    logic [HW-1:0] hic;
    logic [CW-1:0] trc;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            spc <= SW'(DIV);
            hic <= '0;
            trc <= CW'(TRAIL);
        end else begin
            if (en) spc <= SW'(1);
            else if (spc != SW'(DIV)) spc <= spc + SW'(1);
            if (!tmg) hic <= '0;
            else if (hic != HW'(HI + 1)) hic <= hic + HW'(1);
            if (last && on) trc <= '0;
            else if (en && trc != CW'(TRAIL)) trc <= trc + CW'(1);
        end
    end

    assert_pulse_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en |-> spc == SW'(DIV));
    assert_high_time_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(tmg) && !$past(kill) |-> hic == HW'(HI));
    assert_strobe_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en |-> tmg);
    // trailing rule for both channels: R6 (receive) and R7 (send)
    assert_trail_R6_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(on) && !$past(kill) |-> $past(trc) == CW'(TRAIL));
    assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(err));
endmodule

bind gapped_tmg_gen gapped_tmg_chk #(.DIV(DIV), .TRAIL(SND_TRAIL)) u_chk_snd (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmg(snd_tmg_o), .en(snd_en_o), .err(snd_err_o),
    .kill(snd_kill_i), .last(snd_last_i), .on(snd_on)
);

bind gapped_tmg_gen gapped_tmg_chk #(.DIV(DIV), .TRAIL(RCV_TRAIL)) u_chk_rcv (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmg(rcv_tmg_o), .en(rcv_en_o), .err(rcv_err_o),
    .kill(rcv_kill_i), .last(rcv_last_i), .on(rcv_on)
);

// File: tb/test_gapped_tmg_gen.sv
module test_gapped_tmg_gen;
    localparam int DIV = 4;
    localparam int HI  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dte = 1'b1, dce = 1'b1;
    logic [1:0] gap = '0, stp = 2'b11, lst = '0, kil = '0;
    logic snd_tmg, snd_en, snd_err, rcv_tmg, rcv_en, rcv_err;

    always #2.5 clk = ~clk;

    gapped_tmg_gen i_gapped_tmg_gen (
        .clk_i(clk), .rst_ni(rst_n), .dte_avail_i(dte), .dce_avail_i(dce),
        .snd_gap_i(gap[0]), .snd_stop_i(stp[0]), .snd_last_i(lst[0]), .snd_kill_i(kil[0]),
        .rcv_gap_i(gap[1]), .rcv_stop_i(stp[1]), .rcv_last_i(lst[1]), .rcv_kill_i(kil[1]),
        .snd_tmg_o(snd_tmg), .snd_en_o(snd_en), .snd_err_o(snd_err),
        .rcv_tmg_o(rcv_tmg), .rcv_en_o(rcv_en), .rcv_err_o(rcv_err)
    );

    int checks = 0, fails = 0, ncyc = 0;
    bit done = 0;
    string tag = "R1";
    int pulses [2];

    // bench model: 0 off, 1 run, 2 hold
    int m_ph = 0;
    int m_st [2], m_cnt [2];
    bit m_gp [2], m_tmg [2], m_en [2], m_err [2];

    function automatic int trail_of(input int ch);
        return (ch == 0) ? 1 : 23;
    endfunction

    function automatic int next_state(input int st, input bit stop, input bit can_stop);
        if (st == 0) return stop ? 0 : 1;
        if (!stop) return 1;
        return can_stop ? 0 : 2;
    endfunction

    task automatic model_reset();
        m_ph = 0;
        for (int ch = 0; ch < 2; ch++) begin
            m_st[ch] = 0; m_cnt[ch] = trail_of(ch);
            m_gp[ch] = 0; m_tmg[ch] = 0; m_en[ch] = 0; m_err[ch] = 0;
        end
    endtask

    task automatic model_step();
        bit both;
        both = dte && dce;
        for (int ch = 0; ch < 2; ch++) begin
            int cm, ns;
            bit take, iss;
            cm = (lst[ch] && m_st[ch] != 0) ? 0 : m_cnt[ch];
            if (kil[ch]) begin
                if (cm < trail_of(ch)) m_err[ch] = 1;
                m_st[ch] = 0; m_tmg[ch] = 0; m_en[ch] = 0; m_gp[ch] = 0;
                m_cnt[ch] = cm;
            end else begin
                m_en[ch] = 0;
                if (m_ph == HI) m_tmg[ch] = 0;
                if (m_ph == 0) begin
                    ns = next_state(m_st[ch], stp[ch], (cm >= trail_of(ch)) && !both);
                    take = gap[ch] && (!both || !m_gp[ch]);
                    iss = (ns != 0) && !take;
                    if (iss && cm < trail_of(ch)) cm++;
                    m_tmg[ch] = iss; m_en[ch] = iss;
                    m_gp[ch] = (ns != 0) && !iss;
                    m_st[ch] = ns;
                end
                m_cnt[ch] = cm;
            end
        end
        m_ph = (m_ph + 1) % DIV;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        ncyc++;
        if (!rst_n) model_reset();
        else model_step();
        check(tag, "snd levels", {snd_tmg, snd_en, snd_err}, {m_tmg[0], m_en[0], m_err[0]});
        check(tag, "rcv levels", {rcv_tmg, rcv_en, rcv_err}, {m_tmg[1], m_en[1], m_err[1]});
        pulses[0] += int'(snd_en);
        pulses[1] += int'(rcv_en);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic clr();
        pulses[0] = 0; pulses[1] = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd7341);
        model_reset();
        clr();
        tag = "R1";
        run(3);
        check("R1", "reset outputs", {snd_tmg, snd_en, snd_err, rcv_tmg, rcv_en, rcv_err}, 0);
        rst_n = 1'b1;
        cyc();
        check("R1", "first sample after reset", {snd_tmg, snd_en, rcv_tmg, rcv_en}, 0);

        // R3 start-up and steady pulsing; R2 shape checked per cycle
        tag = "R3"; stp = 2'b00; clr(); run(40);
        check("R3", "snd pulses in 10 slots", pulses[0], 10);
        check("R3", "rcv pulses in 10 slots", pulses[1], 10);

        // R4 gaps limited to single omissions while both are available
        tag = "R4"; gap = 2'b11; clr(); run(40);
        check("R4", "snd pulses with constant gap request", pulses[0], 5);
        check("R4", "rcv pulses with constant gap request", pulses[1], 5);

        // R5 long gaps once one end is unavailable
        tag = "R5"; dte = 1'b0; clr(); run(40);
        check("R5", "snd pulses during long gap", pulses[0], 0);
        check("R5", "rcv pulses during long gap", pulses[1], 0);
        gap = 2'b00; dte = 1'b1; run(8);

        // R8 disable ignored while both available
        tag = "R8"; stp = 2'b11; clr(); run(40);
        check("R8", "snd keeps running", pulses[0], 10);
        check("R8", "rcv keeps running", pulses[1], 10);
        dce = 1'b0; clr(); run(40);
        check("R8", "snd stops once an end drops", pulses[0], 0);
        check("R8", "rcv stops once an end drops", pulses[1], 0);

        // R11 marker while stopped is ignored
        tag = "R11"; lst = 2'b11; cyc(); lst = 2'b00;
        clr(); stp = 2'b00; run(4); stp = 2'b11; run(20);
        check("R11", "snd single pulse then stop", pulses[0], 1);
        check("R11", "rcv single pulse then stop", pulses[1], 1);

        // R6 / R7 trailing pulses
        tag = "R6"; dce = 1'b1; stp = 2'b00; run(40);
        lst = 2'b11; stp = 2'b11; dce = 1'b0; clr(); cyc(); lst = 2'b00; run(200);
        check("R7", "snd trailing pulses", pulses[0], 1);
        check("R6", "rcv trailing pulses", pulses[1], 23);

        // R9 held disable, then withdrawn
        tag = "R9"; stp = 2'b00; run(40);
        lst = 2'b10; stp = 2'b11; cyc(); lst = 2'b00; run(20);
        stp = 2'b00; clr(); run(40);
        check("R9", "rcv running after withdrawal", pulses[1], 10);

        // R10 force-off during drain
        tag = "R10"; run(8);
        lst = 2'b11; stp = 2'b11; cyc(); lst = 2'b00; run(12);
        kil = 2'b10; cyc(); kil = 2'b00;
        check("R10", "rcv clock low after force-off", rcv_tmg, 0);
        check("R10", "rcv error raised", rcv_err, 1);
        check("R10", "snd error clear (count complete)", snd_err, 0);
        clr(); run(40);
        check("R10", "rcv error sticky", rcv_err, 1);
        check("R10", "rcv stopped after force-off", pulses[1], 0);

        // random mix, all requirements R2 R4 R5 R6 R7 R8 R9 R10 compared per cycle
        tag = "R2/random";
        for (int i = 0; i < 3000; i++) begin
            gap = 2'(($urandom % 3 == 0) ? 2'b11 : 2'b00) ^ 2'($urandom % 4 == 0);
            if ($urandom % 16 == 0) stp = 2'($urandom);
            lst = {1'($urandom % 20 == 0), 1'($urandom % 20 == 0)};
            kil = {1'($urandom % 300 == 0), 1'($urandom % 300 == 0)};
            if ($urandom % 30 == 0) dte = ~dte;
            if ($urandom % 30 == 0) dce = ~dce;
            cyc();
        end
        finish_up();
    end

    initial begin
        while (ncyc < 20000 && !done) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected finish", ncyc);
            finish_up();
        end
    end
endmodule